// File: doc/BRIEF.md
# 8-bit ALU with Selective Flag Update

This block is the arithmetic and logic stage of a small 8-bit processor. Each accepted operation takes two operands and, for the shift, rotate and bit-test operations, a 3-bit count or bit index. One clock edge later it delivers a registered result and an updated flag word. The flag word holds four flags: zero, carry, overflow and sign. Each operation class touches only its own subset of these flags, and every other flag keeps its previous value. A compare behaves as a subtract that writes no result. The bit test reports a set bit by setting the zero flag.

The surrounding core owns the register file and the branch logic. It reads `res_out` when `res_wr` pulses, and it uses `flags_out` for conditional execution. It can overwrite the flag word through `flags_ld`/`flags_in`, which serves flag restore after an interrupt or a pop. With `op_valid` low and no load, both the result and the flags hold.

Top module: `alu8_flagged`

## Requirements
- R1: While `rst_n` is low at a rising edge, `res_out`, `flags_out` and `res_wr` become zero.
- R2: An op accepted at a rising edge (`op_valid` high) is reflected in `res_out`, `res_wr` and `flags_out` after that same edge. `res_wr` is high for exactly that one cycle, and only for ops that write a result (AND, OR, XOR, INC, DEC, ADD, SUB, SHL, SHR, ROL, ROR). For every other op, `res_out` keeps its value.
- R3: AND, OR and XOR produce the bitwise result and update only ZF (result is zero) and SF (result bit 7). CF and OF are kept.
- R4: ADD and SUB (a minus b) write the 8-bit result. CF is the carry out (ADD) or the borrow (SUB, set when a < b unsigned). OF is two's-complement overflow. ZF and SF follow the result.
- R5: INC and DEC write a+1 and a-1. CF and OF are both set exactly when the value wraps: 0xFF to 0x00 for INC, 0x00 to 0xFF for DEC. ZF and SF follow the result.
- R6: CMP sets ZF, CF, OF and SF exactly as SUB does for the same operands. It writes no result.
- R7: SHL and SHR shift operand a by the count (0 to 7), filling with zeros. CF is the last bit shifted out. A count of 0 leaves the value unchanged and clears CF. ZF and SF follow the result, and OF is kept.
- R8: ROL and ROR rotate operand a by the count (0 to 7). CF is the last bit moved around, which is result bit 0 for ROL and result bit 7 for ROR. A count of 0 leaves the value unchanged and clears CF. ZF and SF follow the result, and OF is kept.
- R9: BIT sets ZF to the value of bit `bit_sel` of operand a, so ZF is 1 when the bit is 1. CF, OF and SF are kept, and no result is written.
- R10: CCF clears CF, SCF sets CF and COF clears OF. The other flags are kept, and no result is written.
- R11: When `flags_ld` is high at an edge, `flags_out` takes `flags_in` in place of any flag update from a simultaneous op. That op's result write still happens.
- R12: Flag bits are ZF bit 0, CF bit 1, OF bit 2 and SF bit 3. The `op_code` values are: AND 0, OR 1, XOR 2, INC 3, DEC 4, ADD 5, SUB 6, CMP 7, SHL 8, SHR 9, ROL 10, ROR 11, BIT 12, CCF 13, SCF 14, COF 15.
- R13: With `op_valid` and `flags_ld` both low, `res_out` and `flags_out` hold and `res_wr` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Accept `op_code` and operands at this edge |
| op_code | input | 4 | Operation select (encoding in R12) |
| opnd_a | input | 8 | First operand; the value shifted, rotated or tested |
| opnd_b | input | 8 | Second operand |
| bit_sel | input | 3 | Shift/rotate count or bit index |
| flags_ld | input | 1 | Overwrite the flag word with `flags_in` |
| flags_in | input | 4 | Flag word to load |
| res_out | output | 8 | Last written result |
| res_wr | output | 1 | One-cycle pulse: `res_out` was just written |
| flags_out | output | 4 | Current flag word |

## Verification
Every result, the write pulse and the flag word are due one rising edge after the op or load is presented. Nothing is combinational from input to output. The bench drives inputs on the falling edge and samples one falling edge later, so that exactly one rising edge lies between stimulus and check. Before each op it loads a flag pattern one cycle earlier, so the cycle that carries the op starts from known flags. This makes every kept flag observable. A directed sequence presents a load and an op at the same edge, then two idle cycles, which checks the single-cycle pulse and the hold behaviour.

// File: rtl/alu8_pkg.sv
// Shared definitions for the 8-bit ALU: flag bit positions, opcode
// encoding and the set of operations that write a result back.
package alu8_pkg;

    localparam int FLAG_W = 4;
    localparam int ZF_B   = 0;
    localparam int CF_B   = 1;
    localparam int OF_B   = 2;
    localparam int SF_B   = 3;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,
        OP_OR  = 4'd1,
        OP_XOR = 4'd2,
        OP_INC = 4'd3,
        OP_DEC = 4'd4,
        OP_ADD = 4'd5,
        OP_SUB = 4'd6,
        OP_CMP = 4'd7,
        OP_SHL = 4'd8,
        OP_SHR = 4'd9,
        OP_ROL = 4'd10,
        OP_ROR = 4'd11,
        OP_BIT = 4'd12,
        OP_CCF = 4'd13,
        OP_SCF = 4'd14,
        OP_COF = 4'd15
    } alu_op_e;

    // True for operations whose result is written to res_out.
    function automatic logic op_writes(alu_op_e op);
        case (op)
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_ADD, OP_SUB,
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/alu8_logic_unit.sv
// Bitwise unit: AND, OR, XOR. Touches only ZF and SF.
// Assumes the caller ORs its outputs with the other units; all outputs
// are zero when the op is not one of this unit's.
module alu8_logic_unit
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e           op,
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    output logic [W-1:0]      res,
    output logic [FLAG_W-1:0] val,
    output logic [FLAG_W-1:0] mask
);

    logic hit;

    // Compute the bitwise result and its zero/sign flags.
    always_comb begin
        hit = 1'b1;
        res = '0;
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: hit = 1'b0;
        endcase
        val  = '0;
        mask = '0;
        if (hit) begin
            val[ZF_B]  = (res == '0);
            val[SF_B]  = res[W-1];
            mask[ZF_B] = 1'b1;
            mask[SF_B] = 1'b1;
        end
    end

endmodule

// File: rtl/alu8_arith_unit.sv
// Adder/subtractor unit: INC, DEC, ADD, SUB and CMP. Updates ZF, CF, OF, SF.
// INC/DEC report an unsigned wrap on both CF and OF, so that a following
// overflow test can carry into an upper byte. ADD/SUB/CMP report signed
// overflow on OF and carry/borrow on CF. Outputs are zero when not selected.
module alu8_arith_unit
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e           op,
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    output logic [W-1:0]      res,
    output logic [FLAG_W-1:0] val,
    output logic [FLAG_W-1:0] mask
);

    localparam logic [W:0] ONE = (W+1)'(1);

    logic [W:0] ext;
    logic       hit;
    logic       ovf;

    // Form the extended sum or difference and the overflow condition.
    always_comb begin
        hit = 1'b1;
        ext = '0;
        ovf = 1'b0;
        case (op)
            OP_INC: begin
                ext = {1'b0, a} + ONE;
                ovf = ext[W];
            end
            OP_DEC: begin
                ext = {1'b0, a} - ONE;
                ovf = ext[W];
            end
            OP_ADD: begin
                ext = {1'b0, a} + {1'b0, b};
                ovf = (a[W-1] == b[W-1]) && (ext[W-1] != a[W-1]);
            end
            OP_SUB, OP_CMP: begin
                ext = {1'b0, a} - {1'b0, b};
                ovf = (a[W-1] != b[W-1]) && (ext[W-1] != a[W-1]);
            end
            default: hit = 1'b0;
        endcase
    end

    // Present result and all four flags for the selected op.
    always_comb begin
        res  = hit ? ext[W-1:0] : '0;
        val  = '0;
        mask = '0;
        if (hit) begin
            val[ZF_B] = (ext[W-1:0] == '0);
            val[CF_B] = ext[W];
            val[OF_B] = ovf;
            val[SF_B] = ext[W-1];
            mask      = '1;
        end
    end

endmodule

// File: rtl/alu8_shift_unit.sv
// Shift/rotate unit: SHL, SHR, ROL, ROR by a count of 0..W-1.
// CF receives the last bit moved out; a zero count leaves the value and
// clears CF. Updates ZF, CF, SF only. Outputs are zero when not selected.
module alu8_shift_unit
    import alu8_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = $clog2(W)
) (
    input  alu_op_e           op,
    input  logic [W-1:0]      a,
    input  logic [CW-1:0]     cnt,
    output logic [W-1:0]      res,
    output logic [FLAG_W-1:0] val,
    output logic [FLAG_W-1:0] mask
);

    logic [W:0]     lft;
    logic [W:0]     rgt;
    logic [2*W-1:0] dbl_l;
    logic [2*W-1:0] dbl_r;
    logic           hit;
    logic           cy;
    logic           nz_cnt;

    // Shifted copies: an extra bit catches the last bit out of a shift,
    // a doubled operand gives the rotations.
    always_comb begin
        lft    = {1'b0, a} << cnt;
        rgt    = {a, 1'b0} >> cnt;
        dbl_l  = {a, a} << cnt;
        dbl_r  = {a, a} >> cnt;
        nz_cnt = (cnt != '0);
    end

    // Pick the variant and its carry.
    always_comb begin
        hit = 1'b1;
        res = '0;
        cy  = 1'b0;
        case (op)
            OP_SHL: begin
                res = lft[W-1:0];
                cy  = lft[W];
            end
            OP_SHR: begin
                res = rgt[W:1];
                cy  = rgt[0];
            end
            OP_ROL: begin
                res = dbl_l[2*W-1:W];
                cy  = nz_cnt & dbl_l[W];
            end
            OP_ROR: begin
                res = dbl_r[W-1:0];
                cy  = nz_cnt & dbl_r[W-1];
            end
            default: hit = 1'b0;
        endcase
        val  = '0;
        mask = '0;
        if (hit) begin
            val[ZF_B]  = (res == '0);
            val[CF_B]  = cy;
            val[SF_B]  = res[W-1];
            mask[ZF_B] = 1'b1;
            mask[CF_B] = 1'b1;
            mask[SF_B] = 1'b1;
        end
    end

endmodule

// File: rtl/alu8_bit_unit.sv
// Flag-only unit: BIT test (ZF = tested bit) and the explicit carry and
// overflow set/clear ops. Produces no result. Outputs zero when not selected.
module alu8_bit_unit
    import alu8_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = $clog2(W)
) (
    input  alu_op_e           op,
    input  logic [W-1:0]      a,
    input  logic [CW-1:0]     idx,
    output logic [FLAG_W-1:0] val,
    output logic [FLAG_W-1:0] mask
);

    // Decode which single flag changes and to what.
    always_comb begin
        val  = '0;
        mask = '0;
        case (op)
            OP_BIT: begin
                val[ZF_B]  = a[idx];
                mask[ZF_B] = 1'b1;
            end
            OP_CCF: mask[CF_B] = 1'b1;
            OP_SCF: begin
                val[CF_B]  = 1'b1;
                mask[CF_B] = 1'b1;
            end
            OP_COF: mask[OF_B] = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_flagged.sv
// Top of the 8-bit ALU. Four execution units decode the op in parallel;
// only the selected unit drives non-zero outputs, so their outputs are
// merged by OR. The flag update is a masked merge into the flag register.
// The result and the write pulse are registered one edge after acceptance.
// Assumes one op per cycle; a flag load wins over a same-cycle flag update.
module alu8_flagged
    import alu8_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [W-1:0]      opnd_a,
    input  logic [W-1:0]      opnd_b,
    input  logic [CW-1:0]     bit_sel,
    input  logic              flags_ld,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [W-1:0]      res_out,
    output logic              res_wr,
    output logic [FLAG_W-1:0] flags_out
);

    alu_op_e           op;
    logic [W-1:0]      res_l, res_a, res_s, res_c;
    logic [FLAG_W-1:0] val_l, val_a, val_s, val_b, val_c;
    logic [FLAG_W-1:0] msk_l, msk_a, msk_s, msk_b, msk_c;
    logic              wr_c;
    logic [W-1:0]      res_q;
    logic              wr_q;
    logic [FLAG_W-1:0] flags_q;

    assign op = alu_op_e'(op_code);

    alu8_logic_unit #(.W(W)) u_logic (
        .op(op), .a(opnd_a), .b(opnd_b),
        .res(res_l), .val(val_l), .mask(msk_l)
    );

    alu8_arith_unit #(.W(W)) u_arith (
        .op(op), .a(opnd_a), .b(opnd_b),
        .res(res_a), .val(val_a), .mask(msk_a)
    );

    alu8_shift_unit #(.W(W), .CW(CW)) u_shift (
        .op(op), .a(opnd_a), .cnt(bit_sel),
        .res(res_s), .val(val_s), .mask(msk_s)
    );

    alu8_bit_unit #(.W(W), .CW(CW)) u_bit (
        .op(op), .a(opnd_a), .idx(bit_sel),
        .val(val_b), .mask(msk_b)
    );

    // Merge the mutually exclusive unit outputs.
    always_comb begin
        res_c = res_l | res_a | res_s;
        val_c = val_l | val_a | val_s | val_b;
        msk_c = msk_l | msk_a | msk_s | msk_b;
        wr_c  = op_valid && op_writes(op);
    end

    // Register the result, the write pulse and the flag word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            wr_q    <= 1'b0;
            flags_q <= '0;
        end else begin
            wr_q <= wr_c;
            if (wr_c) begin
                res_q <= res_c;
            end
            if (flags_ld) begin
                flags_q <= flags_in;
            end else if (op_valid) begin
                flags_q <= (flags_q & ~msk_c) | (val_c & msk_c);
            end
        end
    end

    assign res_out   = res_q;
    assign res_wr    = wr_q;
    assign flags_out = flags_q;

endmodule

// File: rtl/alu8_chk.sv
// Property checker for alu8_flagged, attached through bind below.
// Observes ports only; all properties are one edge deep.
module alu8_chk
    import alu8_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = $clog2(W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic [W-1:0]      opnd_a,
    input logic [W-1:0]      opnd_b,
    input logic [CW-1:0]     bit_sel,
    input logic              flags_ld,
    input logic [FLAG_W-1:0] flags_in,
    input logic [W-1:0]      res_out,
    input logic              res_wr,
    input logic [FLAG_W-1:0] flags_out
);

    logic op_go;
    logic op_is_logic;
    logic op_has_res;

    // Classify the presented op for the properties below.
    always_comb begin
        op_go       = op_valid && !flags_ld;
        op_is_logic = (op_code == OP_AND) || (op_code == OP_OR) || (op_code == OP_XOR);
        op_has_res  = op_writes(alu_op_e'(op_code));
    end

    // R11
    flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_ld |=> flags_out == $past(flags_in));

    // R3
    logic_keeps_co_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && op_is_logic) |=> flags_out[OF_B:CF_B] == $past(flags_out[OF_B:CF_B]));

    // R5
    inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && op_code == OP_INC && opnd_a == '1)
            |=> flags_out[OF_B] && flags_out[CF_B] && flags_out[ZF_B] && res_out == '0);

    // R6
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CMP) |=> !res_wr && $stable(res_out));

    // R9
    bit_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && op_code == OP_BIT)
            |=> flags_out[ZF_B] == $past(opnd_a[bit_sel])
                && flags_out[SF_B:CF_B] == $past(flags_out[SF_B:CF_B]));

    // R2
    zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && op_has_res)
            |=> res_wr && flags_out[SF_B] == res_out[W-1]
                && flags_out[ZF_B] == (res_out == '0));

    // R10
    set_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && op_code == OP_SCF) |=> flags_out[CF_B] && !res_wr);

    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !flags_ld) |=> $stable(flags_out) && $stable(res_out) && !res_wr);

endmodule

bind alu8_flagged alu8_chk #(.W(W), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .bit_sel(bit_sel),
    .flags_ld(flags_ld), .flags_in(flags_in),
    .res_out(res_out), .res_wr(res_wr), .flags_out(flags_out)
);

// File: tb/sim_alu8_flagged.sv
`timescale 1ns/1ps
// Sweep bench for alu8_flagged: every op over wide operand sets, each
// preceded by a flag-pattern load so that kept flags are observable.
module sim_alu8_flagged;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic [2:0] bit_sel = '0;
    logic       flags_ld = 1'b0;
    logic [3:0] flags_in = '0;
    logic [7:0] res_out;
    logic       res_wr;
    logic [3:0] flags_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] last_res = '0;
    bit done = 0;

    always #2 clk = ~clk;

    alu8_flagged u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .bit_sel(bit_sel),
        .flags_ld(flags_ld), .flags_in(flags_in),
        .res_out(res_out), .res_wr(res_wr), .flags_out(flags_out)
    );

    function automatic string tag_of(int op);
        case (op)
            0, 1, 2:  return "R3";
            5, 6:     return "R4";
            3, 4:     return "R5";
            7:        return "R6";
            8, 9:     return "R7";
            10, 11:   return "R8";
            12:       return "R9";
            default:  return "R10";
        endcase
    endfunction

    // Reference model, bit-serial for shifts; flags ZF0 CF1 OF2 SF3 (R12).
    task automatic model(input int op, input int a, input int b, input int n,
                         input logic [3:0] fin, output logic [7:0] r,
                         output logic wr, output logic [3:0] f);
        int s, sa, sb;
        logic [7:0] v;
        logic c;
        f  = fin;
        r  = 8'h00;
        wr = 1'b1;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        case (op)
            0, 1, 2: begin
                r = (op == 0) ? 8'(a & b) : (op == 1) ? 8'(a | b) : 8'(a ^ b);
                f[0] = (r == 0); f[3] = r[7];
            end
            3, 4, 5, 6, 7: begin
                if (op == 3) begin s = a + 1; f[1] = (a == 255); f[2] = (a == 255); end
                else if (op == 4) begin s = a - 1; f[1] = (a == 0); f[2] = (a == 0); end
                else if (op == 5) begin
                    s = a + b; f[1] = (s > 255);
                    f[2] = ((sa + sb) > 127) || ((sa + sb) < -128);
                end else begin
                    s = a - b; f[1] = (a < b);
                    f[2] = ((sa - sb) > 127) || ((sa - sb) < -128);
                end
                r = 8'(s & 255);
                f[0] = (r == 0); f[3] = r[7];
                if (op == 7) wr = 1'b0;
            end
            8, 9, 10, 11: begin
                v = 8'(a); c = 1'b0;
                for (int k = 0; k < n; k++) begin
                    if (op == 8)       begin c = v[7]; v = {v[6:0], 1'b0}; end
                    else if (op == 9)  begin c = v[0]; v = {1'b0, v[7:1]}; end
                    else if (op == 10) begin c = v[7]; v = {v[6:0], v[7]}; end
                    else               begin c = v[0]; v = {v[0], v[7:1]}; end
                end
                r = v;
                f[0] = (r == 0); f[1] = c; f[3] = r[7];
            end
            12: begin wr = 1'b0; f[0] = a[n]; end
            13: begin wr = 1'b0; f[1] = 1'b0; end
            14: begin wr = 1'b0; f[1] = 1'b1; end
            default: begin wr = 1'b0; f[2] = 1'b0; end
        endcase
    endtask

    task automatic check(input string tag, input logic [7:0] er, input logic ew,
                         input logic [3:0] ef);
        checks++;
        if (res_out !== er || res_wr !== ew || flags_out !== ef) begin
            errors++;
            $display("FAIL %s: res=%02h wr=%0b flags=%04b, expected res=%02h wr=%0b flags=%04b",
                     tag, res_out, res_wr, flags_out, er, ew, ef);
        end
    endtask

    // Load flags, issue one op, sample one edge later.
    task automatic run_op(input int op, input int a, input int b, input int n,
                          input logic [3:0] pat);
        logic [7:0] r;
        logic wr;
        logic [3:0] f;
        @(negedge clk);
        flags_ld = 1'b1; flags_in = pat; op_valid = 1'b0;
        @(negedge clk);
        flags_ld = 1'b0; op_valid = 1'b1;
        op_code = 4'(op); opnd_a = 8'(a); opnd_b = 8'(b); bit_sel = 3'(n);
        @(negedge clk);
        op_valid = 1'b0;
        model(op, a, b, n, pat, r, wr, f);
        if (!wr) r = last_res;
        check(tag_of(op), r, wr, f);
        last_res = r;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", 8'h00, 1'b0, 4'b0000);
        rst_n = 1'b1;

        // R3 R4 R6: two-operand ops over all a and twelve b values
        for (int op = 0; op < 8; op++) begin
            if (op == 3 || op == 4) continue;
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b += 23)
                    run_op(op, a, b, 0, 4'((a ^ (b >> 2) ^ op) & 15));
        end
        // R4: boundary pairs
        run_op(5, 8'h7f, 8'h01, 0, 4'h0);
        run_op(5, 8'hff, 8'h01, 0, 4'hf);
        run_op(6, 8'h80, 8'h01, 0, 4'h0);
        run_op(6, 8'h00, 8'h01, 0, 4'hf);
        // R5: INC and DEC over every value including both wraps
        for (int op = 3; op < 5; op++)
            for (int a = 0; a < 256; a++)
                run_op(op, a, 0, 0, 4'((a + op) & 15));
        // R7 R8: shifts and rotates, all values and counts
        for (int op = 8; op < 12; op++)
            for (int a = 0; a < 256; a++)
                for (int n = 0; n < 8; n++)
                    run_op(op, a, 0, n, 4'((a ^ n ^ 4'hA) & 15));
        // R9: BIT over all values and indices
        for (int a = 0; a < 256; a++)
            for (int n = 0; n < 8; n++)
                run_op(12, a, 0, n, 4'((a + n) & 15));
        // R10 R12: explicit flag ops from every starting pattern
        for (int op = 13; op < 16; op++)
            for (int p = 0; p < 16; p++)
                run_op(op, 0, 0, 0, 4'(p));

        // R11: load and op at the same edge; load wins, result still written
        @(negedge clk);
        flags_ld = 1'b1; flags_in = 4'b1010;
        op_valid = 1'b1; op_code = 4'd5; opnd_a = 8'h01; opnd_b = 8'h01;
        @(negedge clk);
        flags_ld = 1'b0; op_valid = 1'b0;
        check("R11", 8'h02, 1'b1, 4'b1010);
        // R2 R13: idle cycles hold state and drop the write pulse
        @(negedge clk);
        opnd_a = 8'h55; opnd_b = 8'hAA; op_code = 4'd0;
        check("R2", 8'h02, 1'b0, 4'b1010);
        @(negedge clk);
        check("R13", 8'h02, 1'b0, 4'b1010);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule